// File: doc/BRIEF.md
# Masked Route-and-Add Prefix Sum Engine

This block turns a vector of sixteen 16-bit words into its running totals: after it finishes, output lane k carries the sum of input lanes 0 up to k. All lanes are captured at once into a row of lane registers. The engine then runs a short fixed sequence of steps. In each step every lane passes its current value a set number of lanes upward, and the receiving lane adds that value to its own. The distance doubles from one step to the next.

Each step takes one clock edge, and every lane updates on that same edge using the values held before it. Lanes that have no sender at the current distance are masked and keep their value. After the final step a one-cycle completion pulse is raised. The totals stay on the outputs until the next vector is accepted. A new vector can be accepted in the same cycle as that pulse, so vectors can be streamed back to back.

Top module: `prefix_scan_top`

## Requirements
- R1: While `rst` is high at a clock edge, all lane registers, `busy` and `done` are cleared to zero on that edge.
- R2: A `start` seen with `busy` low loads lane k with `vec_in[16k+15:16k]` for every k on that edge. From the next cycle `sums` shows the vector unchanged and `busy` is high.
- R3: Lanes below the current distance are masked and hold their value. Lane 0 therefore stays equal to input element 0 for the whole run.
- R4: The distances are 1, 2, 4 and 8, one per edge. After the step with distance d, lane i holds the sum of elements max(0, i-2d+1) through i.
- R5: After the last step, lane k of `sums` equals the sum of elements 0 through k, taken modulo 2^16.
- R6: `done` is high for exactly one cycle, in the fifth cycle after the edge that accepted `start`. `busy` is low in that cycle.
- R7: `busy` stays high from the edge that accepts `start` until the edge that raises `done`. `busy` and `done` are never high together.
- R8: A `start` seen while `busy` is high is ignored. The running sequence and its results are not disturbed.
- R9: A `start` seen in the cycle where `done` is high is accepted as a new vector.
- R10: Once the run is complete, `sums` keeps the totals and `done` stays low until another `start` is accepted.

Top module port `vec_in` carries lane k in bits [16k+15:16k], and `sums` uses the same layout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to load `vec_in` and begin a run |
| vec_in | input | 256 | Sixteen packed input words, lane k at [16k+15:16k] |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse after the final step |
| sums | output | 256 | Sixteen packed lane registers, same layout as `vec_in` |

## Verification
Two events can fall in one cycle: the completion pulse of one run and the acceptance of the next vector. The bench provokes this by raising `start` with a new vector in the exact cycle where `done` is high. It then checks that the first run's totals were visible in that cycle, and that the following cycle shows the new vector loaded, `busy` high and `done` low. It also raises `start` with a different vector in the middle of a run. Every partial and final total of the original vector must still match, which shows the stray request was ignored.

// File: rtl/prefix_pkg.sv
package prefix_pkg;
  parameter int PE_COUNT = 16;
  parameter int WORD_W   = 16;

  function automatic int steps_for(input int lanes);
    int s;
    s = 0;
    while ((1 << s) < lanes) s++;
    return s;
  endfunction
endpackage

// File: rtl/prefix_ctrl.sv
module prefix_ctrl #(
  parameter int STEPS = 4,
  localparam int ST_W = (STEPS > 1) ? $clog2(STEPS) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  output logic            load,
  output logic            step_act,
  output logic [ST_W-1:0] step_idx,
  output logic            busy,
  output logic            done
);
  localparam logic [ST_W-1:0] LAST = ST_W'(STEPS - 1);

  assign load     = start && !busy;
  assign step_act = busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      step_idx <= '0;
    end else begin
      done <= 1'b0;
      if (load) begin
        busy     <= 1'b1;
        step_idx <= '0;
      end else if (busy) begin
        if (step_idx == LAST) begin
          busy     <= 1'b0;
          done     <= 1'b1;
          step_idx <= '0;
        end else begin
          step_idx <= step_idx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/prefix_pe.sv
module prefix_pe #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         add_en,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] addend,
  output logic [W-1:0] acc
);
  always_ff @(posedge clk) begin
    if (rst)         acc <= '0;
    else if (load)   acc <= load_val;
    else if (add_en) acc <= acc + addend;
  end
endmodule

// File: rtl/prefix_pe_array.sv
module prefix_pe_array #(
  parameter int N_PE  = 16,
  parameter int W     = 16,
  parameter int STEPS = 4,
  localparam int ST_W = (STEPS > 1) ? $clog2(STEPS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step_act,
  input  logic [ST_W-1:0]   step_idx,
  input  logic [N_PE*W-1:0] vec_in,
  output logic [N_PE*W-1:0] lanes_out
);
  logic [W-1:0] lane [N_PE];

  for (genvar gi = 0; gi < N_PE; gi++) begin : g_lane
    logic [W-1:0]     route [STEPS];
    logic [STEPS-1:0] live;
    logic             add_en;

    for (genvar gs = 0; gs < STEPS; gs++) begin : g_dist
      if (gi >= (1 << gs)) begin : g_src
        assign route[gs] = lane[gi - (1 << gs)];
        assign live[gs]  = 1'b1;
      end else begin : g_masked
        assign route[gs] = '0;
        assign live[gs]  = 1'b0;
      end
    end

    assign add_en = step_act && live[step_idx];

    prefix_pe #(.W(W)) u_pe (
      .clk      (clk),
      .rst      (rst),
      .load     (load),
      .add_en   (add_en),
      .load_val (vec_in[gi*W +: W]),
      .addend   (route[step_idx]),
      .acc      (lane[gi])
    );

    assign lanes_out[gi*W +: W] = lane[gi];
  end
endmodule

// File: rtl/prefix_scan_top.sv
module prefix_scan_top #(
  parameter int N_PE   = prefix_pkg::PE_COUNT,
  parameter int WORD_W = prefix_pkg::WORD_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic [N_PE*WORD_W-1:0] vec_in,
  output logic                   busy,
  output logic                   done,
  output logic [N_PE*WORD_W-1:0] sums
);
  localparam int STEPS = prefix_pkg::steps_for(N_PE);
  localparam int ST_W  = (STEPS > 1) ? $clog2(STEPS) : 1;

  logic            load;
  logic            step_act;
  logic [ST_W-1:0] step_idx;

  prefix_ctrl #(.STEPS(STEPS)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .load     (load),
    .step_act (step_act),
    .step_idx (step_idx),
    .busy     (busy),
    .done     (done)
  );

  prefix_pe_array #(.N_PE(N_PE), .W(WORD_W), .STEPS(STEPS)) u_array (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .step_act  (step_act),
    .step_idx  (step_idx),
    .vec_in    (vec_in),
    .lanes_out (sums)
  );
endmodule

// File: rtl/prefix_scan_chk.sv
module prefix_scan_chk #(
  parameter int N_PE   = 16,
  parameter int WORD_W = 16
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   start,
  input logic [N_PE*WORD_W-1:0] vec_in,
  input logic                   busy,
  input logic                   done,
  input logic [N_PE*WORD_W-1:0] sums
);
  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({busy, done}));

  // R6
  done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(busy));

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (busy && sums == $past(vec_in)));

  // R8
  start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (start && busy) |=> (busy || done));

  // R3
  lane0_hold_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(sums[WORD_W-1:0]));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable(sums));
endmodule

bind prefix_scan_top prefix_scan_chk #(.N_PE(N_PE), .WORD_W(WORD_W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .start  (start),
  .vec_in (vec_in),
  .busy   (busy),
  .done   (done),
  .sums   (sums)
);

// File: tb/prefix_scan_top_bench.sv
`timescale 1ns/1ps
module prefix_scan_top_bench;
  localparam int N = 16;
  localparam int W = 16;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           start = 1'b0;
  logic [N*W-1:0] vec_in = '0;
  logic           busy;
  logic           done;
  logic [N*W-1:0] sums;

  int  checks = 0;
  int  fails  = 0;
  bit  finished = 1'b0;
  logic [W-1:0] ev [N];

  always #2.5 clk = ~clk;

  prefix_scan_top u_prefix_scan_top (
    .clk(clk), .rst(rst), .start(start), .vec_in(vec_in),
    .busy(busy), .done(done), .sums(sums)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] win_sum(input int i, input int win);
    logic [W-1:0] s = '0;
    int lo = i - win + 1;
    if (lo < 0) lo = 0;
    for (int j = lo; j <= i; j++) s = s + ev[j];
    return s;
  endfunction

  function automatic logic [N*W-1:0] pack_ev();
    logic [N*W-1:0] p;
    for (int k = 0; k < N; k++) p[k*W +: W] = ev[k];
    return p;
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Loads ev at the current negedge, then checks each step; returns at the
  // negedge where done is expected high. stray=1 sends a start mid-run (R8).
  task automatic run_vec(input bit stray);
    vec_in = pack_ev();
    start  = 1'b1;
    tick();
    start  = 1'b0;
    chk("R2 busy after load", {15'b0, busy}, 16'h1);
    chk("R7 done low after load", {15'b0, done}, 16'h0);
    for (int k = 0; k < N; k++) chk("R2 loaded lane", sums[k*W +: W], ev[k]);
    for (int s = 0; s < 4; s++) begin
      if (stray && s == 1) begin
        vec_in = ~pack_ev();
        start  = 1'b1;
      end
      tick();
      start = 1'b0;
      for (int k = 0; k < N; k++)
        chk((s == 3) ? "R5 final sum" : "R4 partial sum", sums[k*W +: W], win_sum(k, 2 << s));
      chk("R3 lane0 held", sums[W-1:0], ev[0]);
      if (s < 3) begin
        chk("R7 busy mid-run", {15'b0, busy}, 16'h1);
        chk("R6 done not early", {15'b0, done}, 16'h0);
      end else begin
        chk("R6 done pulse", {15'b0, done}, 16'h1);
        chk("R7 busy low with done", {15'b0, busy}, 16'h0);
      end
    end
  endtask

  task automatic idle_hold();
    for (int c = 0; c < 3; c++) begin
      tick();
      chk("R6 done one cycle", {15'b0, done}, 16'h0);
      chk("R10 busy stays low", {15'b0, busy}, 16'h0);
      for (int k = 0; k < N; k++) chk("R10 sums held", sums[k*W +: W], win_sum(k, N));
    end
  endtask

  initial begin
    logic [31:0] seed;
    @(negedge clk);
    tick();
    chk("R1 busy in reset", {15'b0, busy}, 16'h0);
    chk("R1 done in reset", {15'b0, done}, 16'h0);
    for (int k = 0; k < N; k++) chk("R1 lane cleared", sums[k*W +: W], 16'h0);
    rst = 1'b0;
    tick();

    for (int k = 0; k < N; k++) ev[k] = 16'(k + 1);
    run_vec(1'b0);
    idle_hold();

    for (int k = 0; k < N; k++) ev[k] = 16'hFFFF;
    run_vec(1'b0);
    idle_hold();

    for (int p = 0; p < N; p++) begin
      for (int k = 0; k < N; k++) ev[k] = (k == p) ? 16'h8001 : 16'h0;
      run_vec(1'b0);
    end
    idle_hold();

    seed = 32'h1234_5678;
    for (int k = 0; k < N; k++) begin
      seed = seed * 32'd1664525 + 32'd1013904223;
      ev[k] = seed[31:16];
    end
    run_vec(1'b1);
    idle_hold();

    // R9: chain runs, new start issued in the cycle done is high
    for (int r = 0; r < 6; r++) begin
      for (int k = 0; k < N; k++) ev[k] = 16'(r * 977 + k * k * 31 + 5);
      run_vec(r == 2);
    end
    idle_hold();

    // R1: reset in the middle of a run
    for (int k = 0; k < N; k++) ev[k] = 16'(k + 100);
    vec_in = pack_ev();
    start = 1'b1;
    tick();
    start = 1'b0;
    tick();
    rst = 1'b1;
    tick();
    chk("R1 busy cleared mid-run", {15'b0, busy}, 16'h0);
    for (int k = 0; k < N; k++) chk("R1 lane cleared mid-run", sums[k*W +: W], 16'h0);
    rst = 1'b0;
    tick();

    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule